// File: doc/BRIEF.md
# Bitfield insert and extract unit

This unit rewrites or pulls out a contiguous bit field of a 32-bit word. It is meant to sit in an execute stage behind an instruction decoder. The decoder supplies the operand values, the low bit position of the field, a 5-bit bound and a 2-bit operation code. The unit then returns the new word one clock later, together with a flag that marks an encoding that makes no sense.

There are two bounded forms and two extraction forms. For clear and insert, the bound is the most significant bit of the field, and only the bits from the low position up to the bound may change in the old destination word. For the two extraction forms, the bound is the field width minus one. The field is then moved down to bit 0 and filled above either with zeros or with copies of its own top bit. A single mask generator, built as a per-bit range compare, serves all four operations, so a full-width field never needs a 32-place shift.

Top module: `bitfield_unit`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, out_valid, undef and result are all zero.
- R2: out_valid is high in exactly the cycle after each cycle with in_valid high. result and undef change only on a cycle that follows in_valid, and hold their value otherwise.
- R3: op_sel 2'b01 (insert) with lsb <= bound replaces destination bits lsb..bound with source bits 0..(bound - lsb). All other bits keep the dst_old value, and undef is low.
- R4: op_sel 2'b00 (clear) with lsb <= bound forces destination bits lsb..bound to zero and keeps all other bits of dst_old. undef is low.
- R5: A field with lsb 0 and bound 31 covers the whole word: insert returns src_val unchanged and clear returns zero.
- R6: For insert or clear with lsb > bound, undef is high and result equals dst_old unchanged.
- R7: op_sel 2'b10 (zero extract) returns src_val bits lsb..lsb+bound in result bits 0..bound, with zeros above.
- R8: op_sel 2'b11 (sign extract) returns the same field as R7, and every result bit above bound equals source bit lsb+bound.
- R9: For either extract, when lsb + bound exceeds 31, undef is high and result is zero.
- R10: A one-bit field (lsb equal to bound, or bound 0 for extract) is handled by the same rules, including at bit 0 and bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe, one operation per cycle |
| op_sel | input | 2 | 00 clear, 01 insert, 10 zero extract, 11 sign extract |
| dst_old | input | 32 | Previous destination word (clear and insert) |
| src_val | input | 32 | Source word |
| lsb | input | 5 | Low bit position of the field |
| bound | input | 5 | Field top bit (clear, insert) or width minus one (extract) |
| out_valid | output | 1 | One-cycle pulse, result ready |
| result | output | 32 | Computed word |
| undef | output | 1 | Invalid encoding for the request |

## Verification
A faulty mask in this block is visible at the ports in the cycle after the request. It shows up as a destination bit outside the field that flips, a field bit that keeps its old value, or missing fill above an extracted field. The one-bit, full-width and bit-31 fields are tested because an off-by-one in the range compare shows up only at those edges. A wrong overrun or ordering test appears as undef at the wrong value, along with a result that is not the old word or zero. A broken output register shows as an out_valid pulse at the wrong time, or as a result that drifts while no request is pending.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
   typedef enum logic [1:0] {
      BF_CLEAR    = 2'b00,
      BF_INSERT   = 2'b01,
      BF_EXT_ZERO = 2'b10,
      BF_EXT_SIGN = 2'b11
   } bf_op_e;
endpackage

// File: rtl/bfu_mask_gen.sv
// Range mask: bit i set when lo <= i <= hi. A per-bit compare avoids
// any shift by the full word width.
module bfu_mask_gen #(
   parameter int DATA_W = 32,
   parameter int POS_W  = $clog2(DATA_W),
   parameter int HI_W   = POS_W + 1
) (
   input  logic [POS_W-1:0]  lo,
   input  logic [HI_W-1:0]   hi,
   output logic [DATA_W-1:0] mask
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      localparam logic [HI_W-1:0] IDX = HI_W'(i);
      assign mask[i] = ({1'b0, lo} <= IDX) && (IDX <= hi);
   end
endmodule

// File: rtl/bfu_field_ops.sv
module bfu_field_ops
   import bfu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int POS_W  = $clog2(DATA_W)
) (
   input  bf_op_e            op,
   input  logic [DATA_W-1:0] dst,
   input  logic [DATA_W-1:0] src,
   input  logic [POS_W-1:0]  lsb,
   input  logic [POS_W-1:0]  bound,
   output logic [DATA_W-1:0] res,
   output logic              bad
);
   localparam int HI_W = POS_W + 1;
   localparam logic [HI_W-1:0] LAST = HI_W'(DATA_W - 1);

   logic [HI_W-1:0]   span_top;
   logic [HI_W-1:0]   mask_hi;
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] placed;
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] low_mask;
   logic [DATA_W-1:0] field;
   logic [DATA_W-1:0] extracted;
   logic              is_ext;
   logic              order_bad;
   logic              span_bad;
   logic              top_bit;

   assign is_ext    = op[1];
   assign span_top  = {1'b0, lsb} + {1'b0, bound};
   assign mask_hi   = is_ext ? span_top : {1'b0, bound};
   assign order_bad = lsb > bound;
   assign span_bad  = span_top > LAST;

   bfu_mask_gen #(.DATA_W(DATA_W), .POS_W(POS_W), .HI_W(HI_W)) mask_i (
      .lo   (lsb),
      .hi   (mask_hi),
      .mask (mask)
   );

   // clear and insert path
   assign placed = (op == BF_INSERT) ? (src << lsb) : '0;
   assign merged = (dst & ~mask) | (placed & mask);

   // extract path
   assign low_mask  = mask >> lsb;
   assign field     = (src & mask) >> lsb;
   assign top_bit   = src[span_top[POS_W-1:0]];
   assign extracted = field | (((op == BF_EXT_SIGN) && top_bit) ? ~low_mask : '0);

   always_comb begin
      if (is_ext) begin
         bad = span_bad;
         res = span_bad ? '0 : extracted;
      end else begin
         bad = order_bad;
         res = order_bad ? dst : merged;
      end
   end
endmodule

// File: rtl/bfu_out_reg.sv
module bfu_out_reg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] res_d,
   input  logic              bad_d,
   output logic              vld_q,
   output logic [DATA_W-1:0] res_q,
   output logic              bad_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         res_q <= '0;
         bad_q <= 1'b0;
      end else begin
         vld_q <= load;
         if (load) begin
            res_q <= res_d;
            bad_q <= bad_d;
         end
      end
   end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
   import bfu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int POS_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        op_sel,
   input  logic [DATA_W-1:0] dst_old,
   input  logic [DATA_W-1:0] src_val,
   input  logic [POS_W-1:0]  lsb,
   input  logic [POS_W-1:0]  bound,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              undef
);
   if (DATA_W < 8 || DATA_W != (1 << POS_W)) begin : g_bad_cfg
      $error("bitfield_unit: DATA_W must be a power of two >= 8 and equal 2**POS_W");
   end

   logic [DATA_W-1:0] res_d;
   logic              bad_d;

   bfu_field_ops #(.DATA_W(DATA_W), .POS_W(POS_W)) ops_i (
      .op    (bf_op_e'(op_sel)),
      .dst   (dst_old),
      .src   (src_val),
      .lsb   (lsb),
      .bound (bound),
      .res   (res_d),
      .bad   (bad_d)
   );

   bfu_out_reg #(.DATA_W(DATA_W)) oreg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (in_valid),
      .res_d (res_d),
      .bad_d (bad_d),
      .vld_q (out_valid),
      .res_q (result),
      .bad_q (undef)
   );
endmodule

// File: rtl/bfu_checker.sv
module bfu_checker #(
   parameter int DATA_W = 32,
   parameter int POS_W  = $clog2(DATA_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [1:0]        op_sel,
   input logic [DATA_W-1:0] dst_old,
   input logic [DATA_W-1:0] src_val,
   input logic [POS_W-1:0]  lsb,
   input logic [POS_W-1:0]  bound,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic              undef
);
   logic [POS_W:0] span;
   logic           over;
   logic           src_top;
   assign span    = {1'b0, lsb} + {1'b0, bound};
   assign over    = span > (POS_W+1)'(DATA_W - 1);
   assign src_top = src_val[span[POS_W-1:0]];

   assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(result) && $stable(undef));
   assert_insert_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op_sel == 2'b01 && lsb <= bound |=>
      !undef && result[$past(lsb)] == $past(src_val[0]));
   assert_clear_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op_sel == 2'b00 && lsb <= bound |=>
      !undef && result[$past(lsb)] == 1'b0);
   assert_order_undef_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !op_sel[1] && lsb > bound |=> undef && result == $past(dst_old));
   assert_zero_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op_sel == 2'b10 && !over && bound != POS_W'(DATA_W - 1) |=>
      !undef && !result[DATA_W-1]);
   assert_sign_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op_sel == 2'b11 && !over |=>
      !undef && result[DATA_W-1] == $past(src_top));
   assert_span_undef_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op_sel[1] && over |=> undef && result == '0);
endmodule

bind bitfield_unit bfu_checker #(.DATA_W(DATA_W), .POS_W(POS_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_sel    (op_sel),
   .dst_old   (dst_old),
   .src_val   (src_val),
   .lsb       (lsb),
   .bound     (bound),
   .out_valid (out_valid),
   .result    (result),
   .undef     (undef)
);

// File: tb/bitfield_unit_tb_top.sv
`timescale 1ns/1ps
module bitfield_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  op_sel = 2'b00;
   logic [31:0] dst_old = '0;
   logic [31:0] src_val = '0;
   logic [4:0]  lsb = '0;
   logic [4:0]  bound = '0;
   logic        out_valid;
   logic [31:0] result;
   logic        undef;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   bitfield_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .dst_old(dst_old), .src_val(src_val), .lsb(lsb), .bound(bound),
      .out_valid(out_valid), .result(result), .undef(undef)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Bit-by-bit expectation built from the requirement text.
   task automatic model(input logic [1:0] op, input logic [31:0] d, input logic [31:0] s,
                        input int l, input int b, output logic [31:0] r, output logic u);
      r = '0;
      u = 1'b0;
      if (op[1] == 1'b0) begin
         if (l > b) begin
            u = 1'b1;
            r = d;
         end else begin
            for (int i = 0; i < 32; i++)
               if (i >= l && i <= b) r[i] = (op == 2'b01) ? s[i-l] : 1'b0;
               else r[i] = d[i];
         end
      end else begin
         if (l + b > 31) u = 1'b1;
         else
            for (int i = 0; i < 32; i++)
               if (i <= b) r[i] = s[l+i];
               else r[i] = (op == 2'b11) ? s[l+b] : 1'b0;
      end
   endtask

   task automatic run_case(input string req, input logic [1:0] op, input logic [31:0] d,
                           input logic [31:0] s, input int l, input int b);
      logic [31:0] er;
      logic        eu;
      model(op, d, s, l, b, er, eu);
      @(negedge clk);
      op_sel = op; dst_old = d; src_val = s; lsb = 5'(l); bound = 5'(b);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      dst_old = ~d; src_val = ~s;
      check({req, " valid"}, 32'(out_valid), 32'd1);
      check({req, " result"}, result, er);
      check({req, " undef"}, 32'(undef), 32'(eu));
      @(negedge clk);
      check({req, " R2 pulse ends"}, 32'(out_valid), 32'd0);
      check({req, " R2 result held"}, result, er);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      check("R1 valid", 32'(out_valid), 32'd0);
      check("R1 result", result, 32'd0);
      check("R1 undef", 32'(undef), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {31'd0, out_valid} | result | 32'(undef), 32'd0);
   endtask

   task automatic t_insert;
      run_case("R3 mid", 2'b01, 32'hFFFF_FFFF, 32'h0000_00A5, 4, 11);
      run_case("R3 high", 2'b01, 32'h1234_5678, 32'hFFFF_FF3C, 20, 29);
      run_case("R3 zeros", 2'b01, 32'hA5A5_A5A5, 32'h0000_0000, 8, 23);
   endtask

   task automatic t_clear;
      run_case("R4 mid", 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3, 17);
      run_case("R4 top", 2'b00, 32'hDEAD_BEEF, 32'h0, 16, 31);
   endtask

   task automatic t_full;
      run_case("R5 insert full", 2'b01, 32'h0F0F_0F0F, 32'hCAFE_F00D, 0, 31);
      run_case("R5 clear full", 2'b00, 32'hCAFE_F00D, 32'h1, 0, 31);
   endtask

   task automatic t_order;
      run_case("R6 insert", 2'b01, 32'h8765_4321, 32'hFFFF_FFFF, 9, 8);
      run_case("R6 clear", 2'b00, 32'h0BAD_F00D, 32'h0, 31, 0);
   endtask

   task automatic t_extract;
      run_case("R7 mid", 2'b10, 32'h0, 32'hF0F8_1234, 12, 7);
      run_case("R7 full", 2'b10, 32'h0, 32'h8000_0001, 0, 31);
      run_case("R8 negative", 2'b11, 32'h0, 32'h0000_0B80, 7, 4);
      run_case("R8 positive", 2'b11, 32'h0, 32'hFFFF_F7FF, 8, 3);
      run_case("R8 top field", 2'b11, 32'h0, 32'h9000_0000, 28, 3);
   endtask

   task automatic t_span;
      run_case("R9 zero ext", 2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 20, 12);
      run_case("R9 sign ext", 2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 31, 1);
   endtask

   task automatic t_single;
      run_case("R10 insert bit0", 2'b01, 32'h0, 32'h1, 0, 0);
      run_case("R10 insert bit31", 2'b01, 32'h0, 32'h1, 31, 31);
      run_case("R10 clear bit31", 2'b00, 32'hFFFF_FFFF, 32'h0, 31, 31);
      run_case("R10 sign bit31", 2'b11, 32'h0, 32'h8000_0000, 31, 0);
      run_case("R10 zero bit5", 2'b10, 32'h0, 32'h0000_0020, 5, 0);
   endtask

   task automatic t_hold;
      run_case("R2 setup", 2'b01, 32'h0, 32'hFF, 0, 7);
      repeat (3) @(negedge clk) begin
         op_sel = 2'b00; dst_old = 32'h1; src_val = 32'h2; lsb = 5'd1; bound = 5'd0;
      end
      check("R2 idle valid", 32'(out_valid), 32'd0);
      check("R2 idle result", result, 32'h0000_00FF);
      check("R2 idle undef", 32'(undef), 32'd0);
   endtask

   initial begin
      t_reset();
      t_insert();
      t_clear();
      t_full();
      t_order();
      t_extract();
      t_span();
      t_single();
      t_hold();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule